// File: doc/BRIEF.md
# Strided Address Generating Sequencer

This block is the controller of a compute cell that keeps its data in a small local memory. A program of wide instruction words is held in an instruction store. Each word names an operation and a repeat count. It also sets up three address walkers: two for the source operands and one for the result. A walker starts at a base address. It moves by a fixed stride for a group of addresses, then takes a longer jump, and then starts a new group. This lets one instruction sweep along the rows or the columns of a matrix held in memory.

An instruction runs in one of two timing styles. In the serial style, each operation takes three cycles: operand read, execute, result write. In the streaming style, used for accumulation and output, the operations overlap, so n operations finish in n+2 cycles. The next word is fetched in the final cycle of the current instruction, so the next instruction begins on the very next cycle. A start pulse runs the program from word 0. It runs until a halt word is fetched.

Top module: `strided_seq`

## Requirements
- R1: An instruction word of 105 bits is laid out, from MSB to LSB, as opcode[104:101], repeat[100:93], then three 31-bit walker fields in this order: operand A [92:62], operand B [61:31], result [30:0]. Each walker field is base[30:22], step[21:13], skip[12:4], group[3:0].
- R2: After reset, `busy`, `rd_en`, `ex_en` and `wr_en` are low and `ex_op` is zero.
- R3: The first address each walker issues in an instruction equals that walker's base field.
- R4: With group field g, a walker issues g+1 addresses that step apart. The next address then adds skip instead of step, and the group restarts.
- R5: Address arithmetic wraps modulo 512.
- R6: An instruction performs repeat+1 operations.
- R7: When opcode bit 3 is 0, each operation uses three consecutive cycles: `rd_en`, then `ex_en`, then `wr_en`. Each cycle has exactly one strobe.
- R8: When opcode bit 3 is 1, n operations occupy n+2 cycles. `rd_en` is high in cycles 0..n-1, `ex_en` in cycles 1..n, and `wr_en` in cycles 2..n+1.
- R9: The first read of a following instruction comes in the cycle right after the last cycle of the current one. After a start pulse, the first read comes two cycles after the edge that samples the start.
- R10: Opcode 0 is a halt. When it is fetched, `busy` falls on the next cycle. A later start runs the program again from word 0.
- R11: A start pulse while `busy` is high has no effect on the running sequence.
- R12: `ex_op` carries the current opcode while `ex_en` is high, and zero at other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run the program from word 0 when idle |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 5 | Instruction store write address |
| prog_wdata | input | 105 | Instruction word to store |
| busy | output | 1 | Sequencer fetching or running |
| rd_en | output | 1 | Operand read strobe |
| rd_addr_a | output | 9 | Operand A address |
| rd_addr_b | output | 9 | Operand B address |
| ex_en | output | 1 | Execute strobe |
| ex_op | output | 4 | Opcode for the execute cycle |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 9 | Result address |

## Verification
The assertions assume that the instruction store is written only while the sequencer is idle. The stimulus keeps to this by loading every program before the start pulse. The walker and strobe properties assume the fetched word does not change between the load cycle and its use, which holds because all writes stay inside idle periods. The programs cover both timing styles, groups of length one and longer, wrap past address 511, a single-operation instruction, a halt in word 0, and a start pulse sent in the middle of a run.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_RUN   = 2'd2
   } sseq_state_e;

   localparam int unsigned NUM_WALKERS = 3;
endpackage

// File: rtl/sseq_imem.sv
module sseq_imem #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned IW    = 105,
   localparam int unsigned PCW  = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           we,
   input  logic [PCW-1:0] waddr,
   input  logic [IW-1:0]  wdata,
   input  logic [PCW-1:0] raddr,
   output logic [IW-1:0]  rdata
);
   logic [IW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/sseq_agen.sv
module sseq_agen #(
   parameter int unsigned AW    = 9,
   parameter int unsigned SUB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    base,
   input  logic [AW-1:0]    step,
   input  logic [AW-1:0]    skip,
   input  logic [SUB_W-1:0] grp_m1,
   input  logic             adv,
   output logic [AW-1:0]    addr
);
   logic [AW-1:0]    addr_q, step_q, skip_q;
   logic [SUB_W-1:0] cnt_q, len_q;
   logic             grp_end;

   assign grp_end = (cnt_q == len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         step_q <= '0;
         skip_q <= '0;
         cnt_q  <= '0;
         len_q  <= '0;
      end else if (load) begin
         addr_q <= base;
         step_q <= step;
         skip_q <= skip;
         len_q  <= grp_m1;
         cnt_q  <= '0;
      end else if (adv) begin
         if (grp_end) begin
            addr_q <= addr_q + skip_q;
            cnt_q  <= '0;
         end else begin
            addr_q <= addr_q + step_q;
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign addr = addr_q;

   assert_first_is_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr == $past(base)));

   assert_group_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= len_q);
endmodule

// File: rtl/sseq_ctrl.sv
module sseq_ctrl
   import sseq_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned OP_W  = 4,
   localparam int unsigned PCW  = $clog2(DEPTH),
   localparam int unsigned TW   = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OP_W-1:0]  op_in,
   input  logic [CNT_W-1:0] rep_in,
   output logic [PCW-1:0]   pc,
   output logic             load,
   output logic             busy,
   output logic             rd_en,
   output logic             ex_en,
   output logic             wr_en,
   output logic [OP_W-1:0]  ex_op
);
   sseq_state_e      st_q;
   logic [PCW-1:0]   pc_q;
   logic [OP_W-1:0]  op_q;
   logic [CNT_W-1:0] rep_q, k_q;
   logic [1:0]       ph_q;
   logic [TW-1:0]    t_q, rep_x;
   logic             pipe, running, last, do_fetch, fetch_ok;
   logic             s_rd, s_ex, s_wr, p_rd, p_ex, p_wr;

   assign running  = (st_q == ST_RUN);
   assign pipe     = op_q[OP_W-1];
   assign rep_x    = {1'b0, rep_q};

   assign s_rd = (ph_q == 2'd0);
   assign s_ex = (ph_q == 2'd1);
   assign s_wr = (ph_q == 2'd2);
   assign p_rd = (t_q <= rep_x);
   assign p_ex = (t_q != '0) && (t_q <= rep_x + TW'(1));
   assign p_wr = (t_q >= TW'(2));

   assign last     = running && (pipe ? (t_q == rep_x + TW'(2))
                                      : (s_wr && (k_q == rep_q)));
   assign do_fetch = (st_q == ST_FETCH) || last;
   assign fetch_ok = (op_in != '0);
   assign load     = do_fetch && fetch_ok;

   assign rd_en = running && (pipe ? p_rd : s_rd);
   assign ex_en = running && (pipe ? p_ex : s_ex);
   assign wr_en = running && (pipe ? p_wr : s_wr);
   assign ex_op = ex_en ? op_q : '0;
   assign busy  = (st_q != ST_IDLE);
   assign pc    = pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         pc_q  <= '0;
         op_q  <= '0;
         rep_q <= '0;
         k_q   <= '0;
         ph_q  <= '0;
         t_q   <= '0;
      end else if (st_q == ST_IDLE) begin
         if (start) begin
            st_q <= ST_FETCH;
            pc_q <= '0;
         end
      end else if (do_fetch) begin
         if (fetch_ok) begin
            st_q  <= ST_RUN;
            op_q  <= op_in;
            rep_q <= rep_in;
            pc_q  <= pc_q + 1'b1;
            k_q   <= '0;
            ph_q  <= '0;
            t_q   <= '0;
         end else begin
            st_q <= ST_IDLE;
         end
      end else if (pipe) begin
         t_q <= t_q + 1'b1;
      end else if (s_wr) begin
         ph_q <= '0;
         k_q  <= k_q + 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assert_read_then_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ex_en);

   assert_exec_then_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ex_en |=> wr_en);

   assert_repeat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (k_q <= rep_q));

   assert_prefetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (last && fetch_ok) |=> (rd_en && busy));

   assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (do_fetch && !fetch_ok) |=> !busy);
endmodule

// File: rtl/strided_seq.sv
module strided_seq
   import sseq_pkg::*;
#(
   parameter int unsigned AW    = 9,
   parameter int unsigned SUB_W = 4,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned OP_W  = 4,
   parameter int unsigned DEPTH = 32,
   localparam int unsigned PCW  = $clog2(DEPTH),
   localparam int unsigned GW   = 3 * AW + SUB_W,
   localparam int unsigned IW   = OP_W + CNT_W + NUM_WALKERS * GW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            prog_we,
   input  logic [PCW-1:0]  prog_addr,
   input  logic [IW-1:0]   prog_wdata,
   output logic            busy,
   output logic            rd_en,
   output logic [AW-1:0]   rd_addr_a,
   output logic [AW-1:0]   rd_addr_b,
   output logic            ex_en,
   output logic [OP_W-1:0] ex_op,
   output logic            wr_en,
   output logic [AW-1:0]   wr_addr
);
   if (DEPTH != (1 << PCW)) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end
   if (OP_W < 2) begin : g_chk_op
      $error("OP_W must be at least 2");
   end
   if (SUB_W > AW) begin : g_chk_sub
      $error("SUB_W must not exceed AW");
   end

   logic [PCW-1:0] pc;
   logic [IW-1:0]  iw;
   logic           load;
   logic [AW-1:0]  w_addr [NUM_WALKERS];
   logic           w_adv  [NUM_WALKERS];

   sseq_imem #(.DEPTH(DEPTH), .IW(IW)) u_imem (
      .clk   (clk),
      .we    (prog_we),
      .waddr (prog_addr),
      .wdata (prog_wdata),
      .raddr (pc),
      .rdata (iw)
   );

   sseq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OP_W(OP_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .op_in  (iw[IW-1 -: OP_W]),
      .rep_in (iw[IW-OP_W-1 -: CNT_W]),
      .pc     (pc),
      .load   (load),
      .busy   (busy),
      .rd_en  (rd_en),
      .ex_en  (ex_en),
      .wr_en  (wr_en),
      .ex_op  (ex_op)
   );

   for (genvar g = 0; g < NUM_WALKERS; g++) begin : g_walker
      localparam int unsigned OFS = (NUM_WALKERS - 1 - g) * GW;
      assign w_adv[g] = (g == NUM_WALKERS - 1) ? wr_en : rd_en;

      sseq_agen #(.AW(AW), .SUB_W(SUB_W)) u_agen (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (load),
         .base   (iw[OFS + GW - 1 -: AW]),
         .step   (iw[OFS + GW - AW - 1 -: AW]),
         .skip   (iw[OFS + SUB_W + AW - 1 -: AW]),
         .grp_m1 (iw[OFS + SUB_W - 1 -: SUB_W]),
         .adv    (w_adv[g]),
         .addr   (w_addr[g])
      );
   end

   assign rd_addr_a = w_addr[0];
   assign rd_addr_b = w_addr[1];
   assign wr_addr   = w_addr[2];

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_en && !ex_en && !wr_en && ex_op == '0));

   assert_op_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ex_en |-> (ex_op != '0));
endmodule

// File: tb/strided_seq_tb.sv
module strided_seq_tb;
   localparam int IW = 105;

   typedef struct packed {
      logic       busy, rd, ex, wr;
      logic [8:0] a, b, d;
      logic [3:0] op;
   } ent_t;

   logic clk = 0, rst_n = 0, start = 0, prog_we = 0;
   logic [4:0]    prog_addr = '0;
   logic [IW-1:0] prog_wdata = '0;
   logic busy, rd_en, ex_en, wr_en;
   logic [8:0] rd_addr_a, rd_addr_b, wr_addr;
   logic [3:0] ex_op;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [IW-1:0] prog [32];
   ent_t exp_q [$];
   int ab [3];
   int ac [3];

   always #4 clk = ~clk;

   strided_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .prog_we(prog_we),
      .prog_addr(prog_addr), .prog_wdata(prog_wdata), .busy(busy),
      .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .ex_en(ex_en), .ex_op(ex_op), .wr_en(wr_en), .wr_addr(wr_addr)
   );

   // R1: walker field base/step/skip/group, word op/repeat/A/B/result
   function automatic logic [30:0] wf(int base, int step, int skip, int grp);
      return {9'(base), 9'(step), 9'(skip), 4'(grp)};
   endfunction

   function automatic logic [IW-1:0] word(int op, int rep, logic [30:0] ga,
                                          logic [30:0] gb, logic [30:0] gd);
      return {4'(op), 8'(rep), ga, gb, gd};
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic put(int a, logic [IW-1:0] w);
      @(negedge clk);
      prog[a] = w;
      prog_we = 1; prog_addr = 5'(a); prog_wdata = w;
      @(negedge clk);
      prog_we = 0;
   endtask

   // behavioural walker: R3 base first, R4 step within group then skip, R5 mod 512
   function automatic int wk_next(int g, logic [IW-1:0] w);
      int ofs = (2 - g) * 31;
      int step = int'(w[ofs+21 -: 9]);
      int skip = int'(w[ofs+12 -: 9]);
      int len  = int'(w[ofs+3 -: 4]);
      int cur  = ab[g];
      if (ac[g] == len) begin ab[g] = (cur + skip) % 512; ac[g] = 0; end
      else begin ab[g] = (cur + step) % 512; ac[g]++; end
      return cur;
   endfunction

   task automatic build_trace();
      int pc = 0;
      ent_t e;
      exp_q.delete();
      e = '0; e.busy = 1;            // fetch cycle after start (R9)
      exp_q.push_back(e);
      forever begin
         logic [IW-1:0] w = prog[pc];
         int op = int'(w[104:101]);
         int n  = int'(w[100:93]) + 1;   // R6
         pc = (pc + 1) % 32;
         if (op == 0) begin              // R10 halt
            e = '0; exp_q.push_back(e); exp_q.push_back(e);
            break;
         end
         for (int g = 0; g < 3; g++) begin
            ab[g] = int'(w[(2-g)*31+30 -: 9]); ac[g] = 0;
         end
         if (w[104]) begin               // R8 streaming timing
            for (int t = 0; t < n + 2; t++) begin
               e = '0; e.busy = 1;
               if (t < n) begin e.rd = 1; e.a = 9'(wk_next(0, w)); e.b = 9'(wk_next(1, w)); end
               if (t >= 1 && t <= n) begin e.ex = 1; e.op = 4'(op); end
               if (t >= 2) begin e.wr = 1; e.d = 9'(wk_next(2, w)); end
               exp_q.push_back(e);
            end
         end else begin                  // R7 serial timing
            for (int k = 0; k < n; k++) begin
               e = '0; e.busy = 1; e.rd = 1;
               e.a = 9'(wk_next(0, w)); e.b = 9'(wk_next(1, w));
               exp_q.push_back(e);
               e = '0; e.busy = 1; e.ex = 1; e.op = 4'(op);
               exp_q.push_back(e);
               e = '0; e.busy = 1; e.wr = 1; e.d = 9'(wk_next(2, w));
               exp_q.push_back(e);
            end
         end
      end
   endtask

   task automatic run_and_compare(int poke_at);
      int idx = 0;
      build_trace();
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      while (exp_q.size() > 0) begin
         ent_t e = exp_q.pop_front();
         check(busy == e.busy, "R10/R11 busy", busy, e.busy);
         check({rd_en, ex_en, wr_en} == {e.rd, e.ex, e.wr}, "R7/R8/R9 strobes",
               {rd_en, ex_en, wr_en}, {e.rd, e.ex, e.wr});
         if (e.rd) begin
            check(rd_addr_a == e.a, "R4 operand A addr", rd_addr_a, e.a);
            check(rd_addr_b == e.b, "R4 operand B addr", rd_addr_b, e.b);
         end
         if (e.wr) check(wr_addr == e.d, "R4 result addr", wr_addr, e.d);
         check(ex_op == e.op, "R12 ex_op", ex_op, e.op);
         start = (idx == poke_at);       // R11: start while busy is ignored
         idx++;
         @(negedge clk);
         start = 0;
      end
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) prog[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R2 reset state
      check(busy == 0, "R2 busy after reset", busy, 0);
      check({rd_en, ex_en, wr_en} == 3'b000, "R2 strobes after reset", {rd_en, ex_en, wr_en}, 0);
      check(ex_op == 0, "R2 ex_op after reset", ex_op, 0);

      // serial, n=3; B wraps past 511 (R5); result group of one uses skip only (R4)
      put(0, word(1, 2, wf(10, 1, 5, 1), wf(500, 7, 0, 15), wf(0, 3, 100, 0)));
      // streaming, n=5; groups of 3 for A, wrap for B (R3 base first)
      put(1, word(9, 4, wf(20, 2, 50, 2), wf(511, 1, 1, 0), wf(300, 4, 0, 3)));
      // serial single operation (R6 repeat 0)
      put(2, word(3, 0, wf(7, 9, 9, 0), wf(8, 1, 1, 1), wf(9, 2, 2, 2)));
      // streaming single operation: three cycles
      put(3, word(12, 0, wf(400, 1, 1, 1), wf(401, 1, 1, 1), wf(402, 1, 1, 1)));
      put(4, '0);

      run_and_compare(5);                // start mid-run (R11)
      run_and_compare(-1);               // restart from word 0 (R10)
      put(0, '0);                        // halt in word 0
      run_and_compare(-1);
      check(busy == 0, "R10 idle after halt", busy, 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule